// File: doc/BRIEF.md
# Debug Event Packetizer

This block turns the byte stream of one memory-access transfer, whether a request or a response, into a series of 16-bit-word event packets for a debug interconnect. Every packet opens with three header words: destination, source, and a flags word that marks the packet as an event of subtype zero. Payload words follow the header. Each payload word packs two transfer bytes, with the earlier byte in the upper half.

The number of payload words per packet is the configured maximum packet length minus the three header words. Every packet of a transfer except the last is filled to that limit. The final packet closes when the input's last-byte marker arrives. If the transfer has an odd byte count, the final word is padded with a zero low byte.

The maximum length, destination and source are sampled when a transfer begins and then held until it ends. Input and output both use valid/ready handshakes. The output's last flag marks the final word of each packet.

Top module: `dbg_evt_pktzr`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: Each packet begins with three words in a fixed order: the destination word, then the source word, then the flags word. out_last_o is never set on any of these three words.
- R3: The flags word is 16'h8000. Bits 15:14 hold the type code 2'b10 (event). Bits 13:10 hold subtype 0. Bits 9:0 are zero.
- R4: In each payload word, the earlier transfer byte is in bits 15:8 and the byte after it is in bits 7:0.
- R5: When a transfer has an odd number of bytes, its final payload word carries the last byte in bits 15:8 and zero in bits 7:0.
- R6: A packet holds at most P payload words, where P = max_pkt_len_i − 3. Every packet except a transfer's final one holds exactly P payload words, so it is max_pkt_len_i words long.
- R7: out_last_o is 1 on the final word of each packet and 0 on every other word. The final packet of a transfer ends with the word that holds the byte marked by in_last_i.
- R8: max_pkt_len_i, dest_i and src_i are sampled once, when the first word of a transfer is ready. Changing them during the transfer has no effect on that transfer's packets.
- R9: A max_pkt_len_i value below 4 is treated as 4, which gives one payload word per packet.
- R10: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o and out_last_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| max_pkt_len_i | input | PKT_LEN_W | Maximum packet length in words, header included |
| dest_i | input | 16 | Destination header word |
| src_i | input | 16 | Source header word |
| in_valid_i | input | 1 | Transfer byte valid |
| in_data_i | input | 8 | Transfer byte |
| in_last_i | input | 1 | Marks the last byte of the transfer |
| in_ready_o | output | 1 | Byte accepted when high together with in_valid_i |
| out_valid_o | output | 1 | Packet word valid |
| out_data_o | output | 16 | Packet word |
| out_last_o | output | 1 | Final word of the current packet |
| out_ready_i | input | 1 | Downstream accepts the word |

## Verification
The bench covers several boundary cases, each with the fault it would expose:
- A transfer that exactly fills one packet. A counter off by one would add an empty packet or split the data early.
- Odd byte counts, including a single byte. A faulty pairer would drop the byte, leave stale data in the low half, or swap the halves.
- Lengths below four. Without the clamp, the payload limit would underflow and packets would never close.
- Changing the configuration in the middle of a transfer. A design that re-reads its inputs would change header words or packet lengths partway through.
- Downstream stalls. A design that lets the output move while it is stalled would lose or duplicate a word.
- A reset in the middle of a transfer. A design that does not clear fully would leak a half-built word into the next transfer.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int HDR_WORDS = 3;
  localparam int TYPE_W    = 2;
  localparam int SUBTYPE_W = 4;

  localparam logic [TYPE_W-1:0]    EVT_TYPE_EVENT = 2'b10;
  localparam logic [SUBTYPE_W-1:0] EVT_SUBTYPE    = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DST,
    ST_SRC,
    ST_FLG,
    ST_PAY
  } frm_state_e;

  function automatic logic [WORD_W-1:0] flags_word();
    return {EVT_TYPE_EVENT, EVT_SUBTYPE, {(WORD_W-TYPE_W-SUBTYPE_W){1'b0}}};
  endfunction
endpackage

// File: rtl/evt_byte_pairer.sv
module evt_byte_pairer
  import dbg_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_last_o,
  input  logic              word_ready_i
);
  logic [BYTE_W-1:0] hi_q;
  logic              hi_vld_q;
  logic [WORD_W-1:0] word_q;
  logic              word_vld_q;
  logic              word_last_q;
  logic              acc;
  logic              emit;

  // Slot frees in the same cycle it drains
  assign byte_ready_o = !word_vld_q || word_ready_i;
  assign acc          = byte_valid_i && byte_ready_o;
  assign emit         = acc && (hi_vld_q || byte_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q        <= '0;
      hi_vld_q    <= 1'b0;
      word_q      <= '0;
      word_vld_q  <= 1'b0;
      word_last_q <= 1'b0;
    end else begin
      if (acc) begin
        if (hi_vld_q) begin
          hi_vld_q <= 1'b0;
        end else if (!byte_last_i) begin
          hi_q     <= byte_i;
          hi_vld_q <= 1'b1;
        end
      end
      if (emit) begin
        word_q      <= hi_vld_q ? {hi_q, byte_i} : {byte_i, {BYTE_W{1'b0}}};
        word_last_q <= byte_last_i;
        word_vld_q  <= 1'b1;
      end else if (word_ready_i) begin
        word_vld_q  <= 1'b0;
      end
    end
  end

  assign word_valid_o = word_vld_q;
  assign word_o       = word_q;
  assign word_last_o  = word_last_q;
endmodule

// File: rtl/evt_cfg_latch.sv
module evt_cfg_latch
  import dbg_evt_pkg::*;
#(
  parameter int PKT_LEN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [PKT_LEN_W-1:0] max_pkt_len_i,
  input  logic [WORD_W-1:0]    dest_i,
  input  logic [WORD_W-1:0]    src_i,
  output logic [WORD_W-1:0]    dest_o,
  output logic [WORD_W-1:0]    src_o,
  output logic [PKT_LEN_W-1:0] pay_max_o
);
  localparam logic [PKT_LEN_W-1:0] MIN_LEN = PKT_LEN_W'(HDR_WORDS + 1);
  localparam logic [PKT_LEN_W-1:0] HDR_LEN = PKT_LEN_W'(HDR_WORDS);

  logic [PKT_LEN_W-1:0] pay_max_d;

  // Clamp so at least one payload word fits
  assign pay_max_d = (max_pkt_len_i < MIN_LEN) ? PKT_LEN_W'(1) : max_pkt_len_i - HDR_LEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_o    <= '0;
      src_o     <= '0;
      pay_max_o <= PKT_LEN_W'(1);
    end else if (start_i) begin
      dest_o    <= dest_i;
      src_o     <= src_i;
      pay_max_o <= pay_max_d;
    end
  end
endmodule

// File: rtl/evt_pkt_framer.sv
module evt_pkt_framer
  import dbg_evt_pkg::*;
#(
  parameter int PKT_LEN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_valid_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 word_last_i,
  output logic                 word_ready_o,
  output logic                 start_o,
  input  logic [WORD_W-1:0]    dest_i,
  input  logic [WORD_W-1:0]    src_i,
  input  logic [PKT_LEN_W-1:0] pay_max_i,
  output logic                 out_valid_o,
  output logic [WORD_W-1:0]    out_data_o,
  output logic                 out_last_o,
  input  logic                 out_ready_i
);
  frm_state_e           state_q;
  logic [PKT_LEN_W-1:0] cnt_q;
  logic                 in_xfer_q;
  logic                 fire;
  logic                 chunk_full;

  assign chunk_full = (cnt_q == pay_max_i - PKT_LEN_W'(1));
  assign start_o    = (state_q == ST_IDLE) && word_valid_i && !in_xfer_q;
  assign fire       = out_valid_o && out_ready_i;

  always_comb begin
    out_valid_o  = 1'b0;
    out_data_o   = '0;
    out_last_o   = 1'b0;
    word_ready_o = 1'b0;
    unique case (state_q)
      ST_DST: begin
        out_valid_o = 1'b1;
        out_data_o  = dest_i;
      end
      ST_SRC: begin
        out_valid_o = 1'b1;
        out_data_o  = src_i;
      end
      ST_FLG: begin
        out_valid_o = 1'b1;
        out_data_o  = flags_word();
      end
      ST_PAY: begin
        out_valid_o  = word_valid_i;
        out_data_o   = word_i;
        out_last_o   = word_valid_i && (word_last_i || chunk_full);
        word_ready_o = out_ready_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      in_xfer_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (word_valid_i) begin
          state_q   <= ST_DST;
          cnt_q     <= '0;
          in_xfer_q <= 1'b1;
        end
        ST_DST: if (fire) state_q <= ST_SRC;
        ST_SRC: if (fire) state_q <= ST_FLG;
        ST_FLG: if (fire) state_q <= ST_PAY;
        ST_PAY: if (fire) begin
          cnt_q <= cnt_q + PKT_LEN_W'(1);
          if (out_last_o) begin
            state_q <= ST_IDLE;
            if (word_last_i) in_xfer_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_evt_pktzr.sv
module dbg_evt_pktzr
  import dbg_evt_pkg::*;
#(
  parameter int PKT_LEN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PKT_LEN_W-1:0] max_pkt_len_i,
  input  logic [15:0]          dest_i,
  input  logic [15:0]          src_i,
  input  logic                 in_valid_i,
  input  logic [7:0]           in_data_i,
  input  logic                 in_last_i,
  output logic                 in_ready_o,
  output logic                 out_valid_o,
  output logic [15:0]          out_data_o,
  output logic                 out_last_o,
  input  logic                 out_ready_i
);
  logic                 word_valid;
  logic [WORD_W-1:0]    word;
  logic                 word_last;
  logic                 word_ready;
  logic                 start;
  logic [WORD_W-1:0]    dest_q;
  logic [WORD_W-1:0]    src_q;
  logic [PKT_LEN_W-1:0] pay_max;

  evt_byte_pairer u_pair (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (in_valid_i),
    .byte_i       (in_data_i),
    .byte_last_i  (in_last_i),
    .byte_ready_o (in_ready_o),
    .word_valid_o (word_valid),
    .word_o       (word),
    .word_last_o  (word_last),
    .word_ready_i (word_ready)
  );

  evt_cfg_latch #(.PKT_LEN_W(PKT_LEN_W)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .max_pkt_len_i (max_pkt_len_i),
    .dest_i        (dest_i),
    .src_i         (src_i),
    .dest_o        (dest_q),
    .src_o         (src_q),
    .pay_max_o     (pay_max)
  );

  evt_pkt_framer #(.PKT_LEN_W(PKT_LEN_W)) u_frm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid),
    .word_i       (word),
    .word_last_i  (word_last),
    .word_ready_o (word_ready),
    .start_o      (start),
    .dest_i       (dest_q),
    .src_i        (src_q),
    .pay_max_i    (pay_max),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_last_o   (out_last_o),
    .out_ready_i  (out_ready_i)
  );
endmodule

// File: rtl/dbg_evt_pktzr_chk.sv
module dbg_evt_pktzr_chk
  import dbg_evt_pkg::*;
#(
  parameter int PKT_LEN_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 out_valid_i,
  input logic [WORD_W-1:0]    out_data_i,
  input logic                 out_last_i,
  input logic                 out_ready_i,
  input logic [PKT_LEN_W-1:0] pay_max_i
);
  logic [PKT_LEN_W:0] beat_q;
  logic [PKT_LEN_W:0] last_beat;

  assign last_beat = {1'b0, pay_max_i} + (PKT_LEN_W+1)'(HDR_WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else if (out_valid_i && out_ready_i) beat_q <= out_last_i ? '0 : beat_q + 1'b1;
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_data_i) && $stable(out_last_i));

  p_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && beat_q == (PKT_LEN_W+1)'(2) |-> out_data_i == 16'h8000);

  p_hdr_no_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && beat_q < (PKT_LEN_W+1)'(HDR_WORDS) |-> !out_last_i);

  p_full_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && beat_q == last_beat |-> out_last_i);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> beat_q <= last_beat);
endmodule

bind dbg_evt_pktzr dbg_evt_pktzr_chk #(.PKT_LEN_W(PKT_LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_i (out_valid_o),
  .out_data_i  (out_data_o),
  .out_last_i  (out_last_o),
  .out_ready_i (out_ready_i),
  .pay_max_i   (pay_max)
);

// File: tb/dbg_evt_pktzr_tb_top.sv
`timescale 1ns/1ps
module dbg_evt_pktzr_tb_top;
  localparam int PKT_LEN_W = 8;
  localparam int N_VEC = 8;
  localparam int V_NB [N_VEC]  = '{4, 5, 1, 20, 7, 12, 9, 2};
  localparam int V_MPL[N_VEC]  = '{5, 5, 8, 6, 2, 7, 5, 3};
  localparam int V_STL[N_VEC]  = '{0, 0, 0, 0, 0, 1, 0, 1};
  localparam int V_CHG[N_VEC]  = '{0, 0, 0, 0, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [PKT_LEN_W-1:0] max_pkt_len;
  logic [15:0] dest, src;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_last, out_ready = 1'b1;
  logic [15:0] out_data;

  dbg_evt_pktzr #(.PKT_LEN_W(PKT_LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .max_pkt_len_i(max_pkt_len),
    .dest_i(dest), .src_i(src),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last), .out_ready_i(out_ready)
  );

  int errs = 0;
  int checks = 0;
  logic [15:0] exp_w[64];
  logic        exp_l[64];
  string       exp_t[64];
  int          n_exp;

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] bval(int v, int i);
    return 8'(v * 37 + i * 11 + 1);
  endfunction

  task automatic build(int v, int nb, int mpl, logic [15:0] d, logic [15:0] s);
    int mp = (mpl < 4) ? 1 : mpl - 3;  // R9 clamp, R6 limit
    int nw = (nb + 1) / 2;
    int wi = 0;
    n_exp = 0;
    while (wi < nw) begin
      exp_w[n_exp] = d;      exp_l[n_exp] = 1'b0; exp_t[n_exp] = "R2 dest"; n_exp++;
      exp_w[n_exp] = s;      exp_l[n_exp] = 1'b0; exp_t[n_exp] = "R2 src";  n_exp++;
      exp_w[n_exp] = 16'h8000; exp_l[n_exp] = 1'b0; exp_t[n_exp] = "R3 flags"; n_exp++;
      for (int k = 0; k < mp && wi < nw; k++) begin
        bit full = (2 * wi + 1 < nb);
        exp_w[n_exp] = {bval(v, 2 * wi), full ? bval(v, 2 * wi + 1) : 8'h00};
        exp_l[n_exp] = (k == mp - 1) || (wi == nw - 1);
        exp_t[n_exp] = full ? "R4 pair" : "R5 pad";
        n_exp++;
        wi++;
      end
    end
  endtask

  task automatic run_vec(int v, int nb, int mpl, bit stall, bit chg);
    @(negedge clk);
    max_pkt_len = PKT_LEN_W'(mpl);
    dest = 16'hD000 + 16'(v);
    src  = 16'hA000 + 16'(v);
    build(v, nb, mpl, dest, src);
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = bval(v, i);
          in_last  = (i == nb - 1);
          if (chg && i == 3) begin  // R8: after latch point
            max_pkt_len = PKT_LEN_W'(40);
            dest = 16'hFFFF;
            src  = 16'hEEEE;
          end
          #1;
          while (!in_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      begin
        int got = 0;
        int k = 0;
        bit pstall = 1'b0;
        logic [15:0] pd = '0;
        logic pl = 1'b0;
        while (got < n_exp) begin
          @(negedge clk);
          out_ready = stall ? (k % 3 != 0) : 1'b1;
          k++;
          #1;
          if (pstall) check(out_valid && out_data == pd && out_last == pl, "R10 hold", out_data, pd);
          pstall = out_valid && !out_ready;
          pd = out_data;
          pl = out_last;
          if (out_valid && out_ready) begin
            check(out_data == exp_w[got], exp_t[got], out_data, exp_w[got]);
            check(out_last == exp_l[got], (got == n_exp - 1) ? "R7 last" : "R6 length",
                  16'(out_last), 16'(exp_l[got]));
            got++;
          end
        end
      end
    join
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check(!out_valid, "R7 end", 16'(out_valid), 16'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    max_pkt_len = PKT_LEN_W'(5);
    dest = '0;
    src = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 valid", 16'(out_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R1 valid", 16'(out_valid), 16'h0);
    check(in_ready, "R1 ready", 16'(in_ready), 16'h1);

    for (int v = 0; v < N_VEC; v++) run_vec(v, V_NB[v], V_MPL[v], V_STL[v] != 0, V_CHG[v] != 0);

    // mid-transfer reset
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 8'h5A;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(!out_valid, "R1 midreset valid", 16'(out_valid), 16'h0);
    check(in_ready, "R1 midreset ready", 16'(in_ready), 16'h1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    run_vec(9, 3, 4, 1'b0, 1'b0);  // R5 odd, R9 boundary len 4

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule